// File: doc/BRIEF.md
# Two-Way Registered Bus Transceiver

This block moves a parallel word between two ports, A and B, along two independent paths: A-to-B and B-to-A. Each path holds one storage cell whose behaviour depends on two controls. With the path's latch enable high, the cell is transparent and its output follows its input without waiting for a clock. With the latch enable low, the cell keeps its contents, except on a rising edge of the path's own clock, where it loads the input word. A falling clock edge, or a clock held steady at either level, leaves the contents alone.

Each path drives its destination port through an output stage. The stage raises a whole-width output-enable vector when its enable pin is active and puts the word on the port. When the enable is inactive, the vector is low, the data lines read zero, and the cell keeps updating behind the stage. The A-to-B enable is active high and the B-to-A enable is active low. Both polarities are parameters. Each bidirectional pad is modelled as an input vector, an output vector and an output-enable vector, and the tri-state pad driver sits outside the block. An asynchronous reset clears both cells.

Top module: `duplex_reg_xcvr`

## Requirements
- R1: While rst_n is low, both storage cells read zero. With an output enabled and its latch enable low, that port drives all-zero data.
- R2: While ab_le is high and ab_oe is high, b_o equals a_i in the same cycle, with no clock edge needed.
- R3: When ab_le falls, the word present on a_i at that moment stays on b_o, even if a_i changes afterwards.
- R4: While ab_le is low, a rising edge of ab_clk loads a_i into the A-to-B cell. b_o shows that word until the next capture or until ab_le rises.
- R5: While ab_le is low, a falling edge of ab_clk and a steady ab_clk have no effect: changes on a_i do not reach b_o.
- R6: ab_oe is active high. When it is 1, every bit of b_oe is 1. When it is 0, every bit of b_oe is 0 and b_o is all zeros.
- R7: The A-to-B cell keeps capturing while its output is disabled. Enabling the output afterwards shows the last captured word.
- R8: The B-to-A path follows R2 to R5 and R7 with ba_le, ba_clk and b_i, and its result appears on a_o.
- R9: ba_oe_n is active low. When it is 0, every bit of a_oe is 1. When it is 1, every bit of a_oe is 0 and a_o is all zeros.
- R10: The two paths are independent. No control or data input of one path changes the outputs of the other path.
- R11: The cell reports its latest event. A clock capture made after a transparent phase replaces the latched word. A transparent phase after a capture replaces the captured word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous reset, active low; clears both cells |
| a_i | input | WIDTH | Word arriving on port A |
| a_o | output | WIDTH | Word driven onto port A (B-to-A path) |
| a_oe | output | WIDTH | Per-bit drive enable for port A |
| b_i | input | WIDTH | Word arriving on port B |
| b_o | output | WIDTH | Word driven onto port B (A-to-B path) |
| b_oe | output | WIDTH | Per-bit drive enable for port B |
| ab_le | input | 1 | A-to-B latch enable; high selects transparent mode |
| ab_clk | input | 1 | A-to-B capture clock; rising edge loads while ab_le is low |
| ab_oe | input | 1 | A-to-B output enable, active high |
| ba_le | input | 1 | B-to-A latch enable; high selects transparent mode |
| ba_clk | input | 1 | B-to-A capture clock; rising edge loads while ba_le is low |
| ba_oe_n | input | 1 | B-to-A output enable, active low |

## Verification
The bench goes after the moment the latch enable falls. A cell that was really a flop would lose the word present at that moment, and one that stayed transparent would let later input changes through. It toggles the path clock low and holds it steady while the input moves, which catches a design that captures on both edges or samples on level. It alternates capture and transparent phases so that a cell which always prefers its flop copy, or always prefers its latch copy, shows a stale word. It also flips the enable polarities and drives one path's controls while watching the other port, which exposes swapped polarity and crossed wiring between the two paths.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
   localparam int unsigned XCVR_DEF_WIDTH = 18;
   typedef enum logic [1:0] {
      XM_HOLD        = 2'b00,
      XM_TRANSPARENT = 2'b01,
      XM_CAPTURE     = 2'b10
   } xcvr_mode_e;
endpackage

// File: rtl/xcvr_store_cell.sv
module xcvr_store_cell #(
   parameter int unsigned WIDTH = xcvr_pkg::XCVR_DEF_WIDTH
) (
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   input  logic             le,
   input  logic             clk,
   output logic [WIDTH-1:0] q
);
   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("xcvr_store_cell: WIDTH must be at least 1");
      end
   endgenerate

   logic [WIDTH-1:0] lat_q;
   logic [WIDTH-1:0] ff_q;
   logic             ff_newer;

   // transparent half: follows d while le is high
   always_latch begin
      if (!rst_n)  lat_q = '0;
      else if (le) lat_q = d;
   end

   // edge half: loads on clk rise while le is low; le high marks latch as newest
   always_ff @(posedge clk or posedge le or negedge rst_n) begin
      if (!rst_n) begin
         ff_newer <= 1'b0;
         ff_q     <= '0;
      end else if (le) begin
         ff_newer <= 1'b0;
      end else begin
         ff_newer <= 1'b1;
         ff_q     <= d;
      end
   end

   always_comb begin
      if (le)            q = d;
      else if (ff_newer) q = ff_q;
      else               q = lat_q;
   end
endmodule

// File: rtl/xcvr_drive.sv
module xcvr_drive #(
   parameter int unsigned WIDTH       = xcvr_pkg::XCVR_DEF_WIDTH,
   parameter bit          ACTIVE_HIGH = 1'b1
) (
   input  logic             en_pin,
   input  logic [WIDTH-1:0] q,
   output logic [WIDTH-1:0] y,
   output logic [WIDTH-1:0] y_oe
);
   logic en;

   generate
      if (ACTIVE_HIGH) begin : g_pol_high
         assign en = en_pin;
      end else begin : g_pol_low
         assign en = ~en_pin;
      end
   endgenerate

   assign y    = en ? q : '0;
   assign y_oe = {WIDTH{en}};
endmodule

// File: rtl/duplex_reg_xcvr.sv
module duplex_reg_xcvr #(
   parameter int unsigned WIDTH        = xcvr_pkg::XCVR_DEF_WIDTH,
   parameter bit          AB_OE_ACT_HI = 1'b1,
   parameter bit          BA_OE_ACT_HI = 1'b0
) (
   input  logic             rst_n,
   input  logic [WIDTH-1:0] a_i,
   output logic [WIDTH-1:0] a_o,
   output logic [WIDTH-1:0] a_oe,
   input  logic [WIDTH-1:0] b_i,
   output logic [WIDTH-1:0] b_o,
   output logic [WIDTH-1:0] b_oe,
   input  logic             ab_le,
   input  logic             ab_clk,
   input  logic             ab_oe,
   input  logic             ba_le,
   input  logic             ba_clk,
   input  logic             ba_oe_n
);
   generate
      if (WIDTH < 1 || WIDTH > 1024) begin : g_bad_width
         $error("duplex_reg_xcvr: WIDTH out of range");
      end
   endgenerate

   logic [WIDTH-1:0] ab_q;
   logic [WIDTH-1:0] ba_q;

   xcvr_store_cell #(.WIDTH(WIDTH)) u_cell_ab (
      .rst_n (rst_n),
      .d     (a_i),
      .le    (ab_le),
      .clk   (ab_clk),
      .q     (ab_q)
   );

   xcvr_store_cell #(.WIDTH(WIDTH)) u_cell_ba (
      .rst_n (rst_n),
      .d     (b_i),
      .le    (ba_le),
      .clk   (ba_clk),
      .q     (ba_q)
   );

   xcvr_drive #(.WIDTH(WIDTH), .ACTIVE_HIGH(AB_OE_ACT_HI)) u_drv_b (
      .en_pin (ab_oe),
      .q      (ab_q),
      .y      (b_o),
      .y_oe   (b_oe)
   );

   xcvr_drive #(.WIDTH(WIDTH), .ACTIVE_HIGH(BA_OE_ACT_HI)) u_drv_a (
      .en_pin (ba_oe_n),
      .q      (ba_q),
      .y      (a_o),
      .y_oe   (a_oe)
   );
endmodule

// File: rtl/duplex_reg_xcvr_chk.sv
module duplex_reg_xcvr_chk #(
   parameter int unsigned WIDTH        = xcvr_pkg::XCVR_DEF_WIDTH,
   parameter bit          AB_OE_ACT_HI = 1'b1,
   parameter bit          BA_OE_ACT_HI = 1'b0
) (
   input logic             rst_n,
   input logic [WIDTH-1:0] a_i,
   input logic [WIDTH-1:0] a_o,
   input logic [WIDTH-1:0] a_oe,
   input logic [WIDTH-1:0] b_i,
   input logic [WIDTH-1:0] b_o,
   input logic [WIDTH-1:0] b_oe,
   input logic             ab_le,
   input logic             ab_clk,
   input logic             ab_oe,
   input logic             ba_le,
   input logic             ba_clk,
   input logic             ba_oe_n
);
   logic ab_en, ba_en;
   assign ab_en = AB_OE_ACT_HI ? ab_oe : ~ab_oe;
   assign ba_en = BA_OE_ACT_HI ? ba_oe_n : ~ba_oe_n;

   always_comb begin
      if (rst_n === 1'b1 && ab_le === 1'b1 && ab_en === 1'b1)
         AST_AB_TRANSPARENT: assert (b_o == a_i); // R2
      if (rst_n === 1'b1 && ba_le === 1'b1 && ba_en === 1'b1)
         AST_BA_TRANSPARENT: assert (a_o == b_i); // R8
      if (rst_n === 1'b0 && ab_le === 1'b0)
         AST_AB_RESET_ZERO: assert (b_o == '0); // R1
      if (rst_n === 1'b0 && ba_le === 1'b0)
         AST_BA_RESET_ZERO: assert (a_o == '0); // R1
      if (b_oe === '0)
         AST_AB_OFF_ZERO: assert (b_o == '0); // R6
      if (a_oe === '0)
         AST_BA_OFF_ZERO: assert (a_o == '0); // R9
      if (rst_n === 1'b1)
         AST_AB_OE_WHOLE: assert (b_oe == '0 || b_oe == '1); // R6
      if (rst_n === 1'b1)
         AST_BA_OE_WHOLE: assert (a_oe == '0 || a_oe == '1); // R9
   end
endmodule

bind duplex_reg_xcvr duplex_reg_xcvr_chk #(
   .WIDTH(WIDTH), .AB_OE_ACT_HI(AB_OE_ACT_HI), .BA_OE_ACT_HI(BA_OE_ACT_HI)
) u_chk (.*);

// File: tb/duplex_reg_xcvr_tb.sv
module duplex_reg_xcvr_tb;
   localparam int W = 18;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic         rst_n;
   logic [W-1:0] a_i, b_i;
   logic [W-1:0] a_o, a_oe, b_o, b_oe;
   logic         ab_le, ab_clk, ab_oe, ba_le, ba_clk, ba_oe_n;

   int checks = 0;
   int fails  = 0;

   duplex_reg_xcvr #(.WIDTH(W)) u_dut (
      .rst_n(rst_n), .a_i(a_i), .a_o(a_o), .a_oe(a_oe),
      .b_i(b_i), .b_o(b_o), .b_oe(b_oe),
      .ab_le(ab_le), .ab_clk(ab_clk), .ab_oe(ab_oe),
      .ba_le(ba_le), .ba_clk(ba_clk), .ba_oe_n(ba_oe_n)
   );

   always @(negedge clk)
      if (ab_oe && !ba_oe_n)
         $display("WARN bus contention: both ports driving at %0t", $time);

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic settle();
      @(negedge clk);
      #1;
   endtask

   task automatic pulse_ab();
      @(negedge clk); ab_clk = 1'b1;
      @(negedge clk); ab_clk = 1'b0;
      #1;
   endtask

   task automatic pulse_ba();
      @(negedge clk); ba_clk = 1'b1;
      @(negedge clk); ba_clk = 1'b0;
      #1;
   endtask

   task automatic t_reset();
      rst_n = 1'b0; a_i = 18'h15A5A; b_i = 18'h2A5A5;
      ab_le = 1'b0; ab_clk = 1'b0; ab_oe = 1'b1;
      ba_le = 1'b0; ba_clk = 1'b0; ba_oe_n = 1'b1;
      settle();
      chk("R1 b_o in reset", b_o, '0);
      ab_oe = 1'b0; ba_oe_n = 1'b0;
      settle();
      chk("R1 a_o in reset", a_o, '0);
      rst_n = 1'b1; ba_oe_n = 1'b1; ab_oe = 1'b1;
      settle();
      chk("R1 b_o after reset release", b_o, '0);
   endtask

   task automatic t_ab_transparent();
      ab_le = 1'b1; a_i = 18'h00F0F;
      #1 chk("R2 transparent first word", b_o, 18'h00F0F);
      a_i = 18'h3C3C3;
      #1 chk("R2 transparent follows without clock", b_o, 18'h3C3C3);
      a_i = 18'h12345;
      settle();
      ab_le = 1'b0;
      #1 a_i = 18'h0BEEF;
      #1 chk("R3 word at le fall retained", b_o, 18'h12345);
      settle();
      chk("R3 still retained later", b_o, 18'h12345);
   endtask

   task automatic t_ab_clock();
      a_i = 18'h2AAAA;
      pulse_ab();
      chk("R4 rising edge captures", b_o, 18'h2AAAA);
      a_i = 18'h15555;
      settle();
      chk("R5 steady low clock ignores input", b_o, 18'h2AAAA);
      @(negedge clk); ab_clk = 1'b1;
      #1 chk("R4 capture on rise", b_o, 18'h15555);
      a_i = 18'h00001;
      settle();
      chk("R5 steady high clock ignores input", b_o, 18'h15555);
      ab_clk = 1'b0;
      #1 chk("R5 falling edge ignored", b_o, 18'h15555);
   endtask

   task automatic t_ab_oe();
      ab_oe = 1'b0;
      #1 chk("R6 b_oe all zero when off", b_oe, '0);
      chk("R6 b_o zero when off", b_o, '0);
      a_i = 18'h3FFFF;
      pulse_ab();
      chk("R7 off while capturing", b_o, '0);
      ab_oe = 1'b1;
      #1 chk("R6 b_oe all one when on", b_oe, '1);
      chk("R7 captured while off shows", b_o, 18'h3FFFF);
   endtask

   task automatic t_ab_order();
      a_i = 18'h11111; ab_le = 1'b1; settle();
      ab_le = 1'b0; settle();
      a_i = 18'h22222; pulse_ab();
      chk("R11 capture after latch wins", b_o, 18'h22222);
      a_i = 18'h33333; ab_le = 1'b1; settle();
      ab_le = 1'b0; #1 a_i = 18'h00000;
      #1 chk("R11 latch after capture wins", b_o, 18'h33333);
      a_i = 18'h04444; pulse_ab();
      a_i = 18'h05555; pulse_ab();
      chk("R11 second capture wins", b_o, 18'h05555);
   endtask

   task automatic t_ba_path();
      ba_oe_n = 1'b1;
      #1 chk("R9 a_oe zero when ba_oe_n high", a_oe, '0);
      chk("R9 a_o zero when off", a_o, '0);
      ba_oe_n = 1'b0;
      #1 chk("R9 a_oe all one when ba_oe_n low", a_oe, '1);
      ba_le = 1'b1; b_i = 18'h0ABCD;
      #1 chk("R8 BA transparent", a_o, 18'h0ABCD);
      ba_le = 1'b0;
      #1 b_i = 18'h3DCBA;
      #1 chk("R8 BA le fall retained", a_o, 18'h0ABCD);
      pulse_ba();
      chk("R8 BA rising edge captures", a_o, 18'h3DCBA);
      b_i = 18'h01010; settle();
      chk("R8 BA steady clock ignores input", a_o, 18'h3DCBA);
      ba_oe_n = 1'b1; b_i = 18'h27272; pulse_ba();
      ba_oe_n = 1'b0;
      #1 chk("R8 BA captured while off shows", a_o, 18'h27272);
   endtask

   task automatic t_independent();
      logic [W-1:0] a_hold, b_hold;
      a_hold = a_o; b_hold = b_o;
      ab_le = 1'b1; a_i = 18'h39393; pulse_ab(); ab_oe = 1'b0;
      #1 chk("R10 AB activity leaves a_o", a_o, a_hold);
      chk("R10 AB activity leaves a_oe", a_oe, '1);
      ab_le = 1'b0; ab_oe = 1'b1;
      #1 b_hold = b_o;
      ba_le = 1'b1; b_i = 18'h06060; pulse_ba(); ba_oe_n = 1'b1;
      #1 chk("R10 BA activity leaves b_o", b_o, b_hold);
      chk("R10 BA activity leaves b_oe", b_oe, '1);
      ba_le = 1'b0; ba_oe_n = 1'b0;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin : main
      t_reset();
      t_ab_transparent();
      t_ab_clock();
      t_ab_oe();
      t_ab_order();
      t_ba_path();
      t_independent();
      settle();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule